// File: doc/BRIEF.md
# Precedence-Ordered Output Queue Selector

This block assigns each classified packet to one of eight output queues of its egress port. Every cycle it may accept one attribute record: the 802.1p priority, the IP type-of-service byte, a 7-bit traffic class, an IP multicast group hit with its index, and two precomputed hits that each carry a queue number, one from the destination-address lookup and one from the VLAN lookup. Six criteria can each propose a queue. The host sets an ordered list of six slots that names these criteria. The first slot whose criterion is enabled and matches the packet decides the queue. A packet that matches no criterion goes to a programmable default queue.

A table indexed by traffic class can also re-mark the packet for DiffServ. When the entry for the packet's class is enabled, the upper six bits of the ToS byte are replaced with a programmed code point and a rewrite flag is raised. The two low bits are always kept. The decision is registered and appears one cycle after the record. The small lookup tables are loaded through a single write port, and the precedence list, enable mask and default queue are static configuration inputs.

Top module: `qsel_top`

## Requirements
- R1: A record presented with `in_valid` high at a clock edge gives `out_valid` high after that edge with its decision. `out_valid` is low after any edge where `in_valid` was low. Back-to-back records give back-to-back decisions.
- R2: While `rst_n` is low, `out_valid` and `out_rewrite` are low. Reset marks every entry of every lookup table invalid or disabled, so before any table write a record that carries no destination-address hit or VLAN hit goes to `cfg_default_q` with its ToS unchanged.
- R3: Slot k sits in `cfg_order[3k+2:3k]`, and slot 0 has the highest precedence. Codes: 0 = 802.1p, 1 = ToS, 2 = traffic class, 3 = multicast group, 4 = destination address, 5 = VLAN. Codes 6 and 7 mark an empty slot, which is skipped.
- R4: The match rules are as follows. 802.1p matches when the priority map entry at `in_pcp` is valid. ToS matches when the ToS map entry at `in_tos[7:5]` is valid. Traffic class matches when the class map entry at `in_class` is valid. Multicast matches when `in_mc_hit` is high and the group map entry at `in_mc_idx` is valid. Each of these four supplies the queue stored in its entry. Destination address matches on `in_da_hit` with queue `in_da_queue`, and VLAN matches on `in_vlan_hit` with queue `in_vlan_queue`.
- R5: The queue comes from the matching criterion in the lowest-numbered usable slot. A non-matching criterion passes the decision to the next slot.
- R6: A criterion whose bit in `cfg_enable` (bit index = code) is clear is skipped in every slot, even when it matches.
- R7: When no slot yields a match, `out_queue` equals `cfg_default_q`.
- R8: A write with `tbl_we` high stores `tbl_data` at `tbl_addr` (truncated to the table size) in the table named by `tbl_sel`. Selectors: 0 = priority map, 1 = ToS map, 2 = class map, 3 = group map, each with data bit 3 = valid and bits 2:0 = queue; 4 = re-mark table, with bit 6 = enable and bits 5:0 = code point. A record in the same cycle as a write sees the old contents, and later records see the new contents.
- R9: When the re-mark entry for `in_class` is enabled, `out_tos` = {code point, `in_tos[1:0]`} and `out_rewrite` is high. Otherwise `out_tos` = `in_tos` and `out_rewrite` is low.
- R10: Writes with `tbl_sel` equal to 5, 6 or 7 change no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Attribute record valid |
| in_pcp | input | 3 | 802.1p priority |
| in_tos | input | 8 | IP type-of-service byte |
| in_class | input | 7 | Traffic class from the classifier |
| in_mc_hit | input | 1 | IP multicast group lookup hit |
| in_mc_idx | input | 4 | Multicast group index |
| in_da_hit | input | 1 | Destination-address priority hit |
| in_da_queue | input | 3 | Queue proposed by the destination-address lookup |
| in_vlan_hit | input | 1 | VLAN priority hit |
| in_vlan_queue | input | 3 | Queue proposed by the VLAN lookup |
| cfg_order | input | 18 | Six 3-bit precedence slots, slot 0 in the low bits |
| cfg_enable | input | 6 | Per-criterion enable, bit index = criterion code |
| cfg_default_q | input | 3 | Queue used when nothing matches |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 3 | Table selector |
| tbl_addr | input | 7 | Table entry address |
| tbl_data | input | 7 | Table entry data |
| out_valid | output | 1 | Decision valid |
| out_queue | output | 3 | Chosen output queue |
| out_tos | output | 8 | ToS byte after optional re-marking |
| out_rewrite | output | 1 | ToS byte was re-marked |

## Verification
Fall-through is the hardest behaviour to reach from the ports. A criterion deep in the list decides only when every slot ahead of it either misses, is empty or has its criterion disabled. The cases where the same match is present but masked out are the ones most likely to hide a priority error. The stimulus programs sparse tables, leaving most entries invalid, and then walks a vector list. Across the vectors the precedence order, the enable mask and the hit inputs change so that a lower slot decides while a higher criterion would also match if it were allowed. One directed case writes a class entry in the same cycle that a record looks it up, which shows the boundary between old and new table contents.

// File: rtl/qsel_pkg.sv
package qsel_pkg;
  localparam int N_CRIT  = 6;
  localparam int CODE_W  = 3;
  localparam int DSCP_W  = 6;

  localparam logic [CODE_W-1:0] C_PCP   = 3'd0;
  localparam logic [CODE_W-1:0] C_TOS   = 3'd1;
  localparam logic [CODE_W-1:0] C_CLASS = 3'd2;
  localparam logic [CODE_W-1:0] C_MCAST = 3'd3;
  localparam logic [CODE_W-1:0] C_DA    = 3'd4;
  localparam logic [CODE_W-1:0] C_VLAN  = 3'd5;

  // Merge a new code point above the two preserved low ToS bits.
  function automatic logic [7:0] remark_tos(input logic [7:0] tos,
                                            input logic en,
                                            input logic [DSCP_W-1:0] dscp);
    return en ? {dscp, tos[1:0]} : tos;
  endfunction
endpackage

// File: rtl/qsel_map_table.sv
module qsel_map_table #(
  parameter int DEPTH = 8,
  parameter int DW    = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && (int'(waddr) == i))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qsel_walk.sv
module qsel_walk #(
  parameter int N_SLOT = 6,
  parameter int N_CRIT = 6,
  parameter int CW     = 3,
  parameter int QW     = 3,
  localparam int N_CODE = 1 << CW
) (
  input  logic [N_SLOT*CW-1:0] order,
  input  logic [N_CRIT-1:0]    enable,
  input  logic [N_CRIT-1:0]    match,
  input  logic [N_CRIT*QW-1:0] crit_q,
  input  logic [QW-1:0]        default_q,
  output logic [QW-1:0]        sel_q,
  output logic                 hit
);
  logic [N_CODE-1:0]    usable;
  logic [N_CODE*QW-1:0] q_ext;

  assign usable = N_CODE'(enable & match);
  assign q_ext  = (N_CODE*QW)'(crit_q);

  always_comb begin
    logic [CW-1:0] code;
    sel_q = default_q;
    hit   = 1'b0;
    // Lowest slot is visited last so it has the final word.
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      code = order[s*CW +: CW];
      if (usable[code]) begin
        sel_q = q_ext[int'(code)*QW +: QW];
        hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qsel_top.sv
module qsel_top #(
  parameter int N_QUEUE = 8,
  parameter int CLASS_W = 7,
  parameter int MC_W    = 4,
  localparam int QW     = $clog2(N_QUEUE),
  localparam int MW     = QW + 1,
  localparam int RW     = qsel_pkg::DSCP_W + 1,
  localparam int N_SLOT = qsel_pkg::N_CRIT,
  localparam int CW     = qsel_pkg::CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           in_pcp,
  input  logic [7:0]           in_tos,
  input  logic [CLASS_W-1:0]   in_class,
  input  logic                 in_mc_hit,
  input  logic [MC_W-1:0]      in_mc_idx,
  input  logic                 in_da_hit,
  input  logic [QW-1:0]        in_da_queue,
  input  logic                 in_vlan_hit,
  input  logic [QW-1:0]        in_vlan_queue,
  input  logic [N_SLOT*CW-1:0] cfg_order,
  input  logic [N_SLOT-1:0]    cfg_enable,
  input  logic [QW-1:0]        cfg_default_q,
  input  logic                 tbl_we,
  input  logic [2:0]           tbl_sel,
  input  logic [CLASS_W-1:0]   tbl_addr,
  input  logic [RW-1:0]        tbl_data,
  output logic                 out_valid,
  output logic [QW-1:0]        out_queue,
  output logic [7:0]           out_tos,
  output logic                 out_rewrite
);
  import qsel_pkg::*;

  logic [MW-1:0] pcp_rd, tos_rd, cls_rd, mc_rd;
  logic [RW-1:0] rmk_rd;
  logic [N_CRIT-1:0]    match;
  logic [N_CRIT*QW-1:0] crit_q;
  logic [QW-1:0]        walk_q;
  logic                 walk_hit;
  logic [4:0]           wr_sel;

  for (genvar t = 0; t < 5; t++) begin : g_wsel
    assign wr_sel[t] = tbl_we && (tbl_sel == 3'(t));
  end

  qsel_map_table #(.DEPTH(8), .DW(MW)) pcp_map_i (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[0]), .waddr(tbl_addr[2:0]),
    .wdata(tbl_data[MW-1:0]), .raddr(in_pcp), .rdata(pcp_rd));

  qsel_map_table #(.DEPTH(8), .DW(MW)) tos_map_i (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[1]), .waddr(tbl_addr[2:0]),
    .wdata(tbl_data[MW-1:0]), .raddr(in_tos[7:5]), .rdata(tos_rd));

  qsel_map_table #(.DEPTH(1 << CLASS_W), .DW(MW)) cls_map_i (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[2]), .waddr(tbl_addr),
    .wdata(tbl_data[MW-1:0]), .raddr(in_class), .rdata(cls_rd));

  qsel_map_table #(.DEPTH(1 << MC_W), .DW(MW)) mc_map_i (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[3]), .waddr(tbl_addr[MC_W-1:0]),
    .wdata(tbl_data[MW-1:0]), .raddr(in_mc_idx), .rdata(mc_rd));

  qsel_map_table #(.DEPTH(1 << CLASS_W), .DW(RW)) rmk_map_i (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[4]), .waddr(tbl_addr),
    .wdata(tbl_data), .raddr(in_class), .rdata(rmk_rd));

  always_comb begin
    match = '0;
    crit_q = '0;
    match[C_PCP]   = pcp_rd[QW];
    match[C_TOS]   = tos_rd[QW];
    match[C_CLASS] = cls_rd[QW];
    match[C_MCAST] = in_mc_hit && mc_rd[QW];
    match[C_DA]    = in_da_hit;
    match[C_VLAN]  = in_vlan_hit;
    crit_q[int'(C_PCP)*QW   +: QW] = pcp_rd[QW-1:0];
    crit_q[int'(C_TOS)*QW   +: QW] = tos_rd[QW-1:0];
    crit_q[int'(C_CLASS)*QW +: QW] = cls_rd[QW-1:0];
    crit_q[int'(C_MCAST)*QW +: QW] = mc_rd[QW-1:0];
    crit_q[int'(C_DA)*QW    +: QW] = in_da_queue;
    crit_q[int'(C_VLAN)*QW  +: QW] = in_vlan_queue;
  end

  qsel_walk #(.N_SLOT(N_SLOT), .N_CRIT(N_CRIT), .CW(CW), .QW(QW)) walk_i (
    .order(cfg_order), .enable(cfg_enable), .match(match), .crit_q(crit_q),
    .default_q(cfg_default_q), .sel_q(walk_q), .hit(walk_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_queue   <= '0;
      out_tos     <= '0;
      out_rewrite <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_queue   <= walk_q;
        out_tos     <= remark_tos(in_tos, rmk_rd[RW-1], rmk_rd[RW-2:0]);
        out_rewrite <= rmk_rd[RW-1];
      end else begin
        out_rewrite <= 1'b0;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  default_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !walk_hit) |=> (out_queue == $past(cfg_default_q)));
  // R9
  low_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_tos[1:0] == $past(in_tos[1:0])));
  // R9
  rewrite_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rewrite |-> out_valid);
  // R9
  tos_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rewrite) |-> (out_tos == $past(in_tos)));
endmodule

// File: tb/qsel_top_tb_top.sv
module qsel_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_pcp = '0;
  logic [7:0] in_tos = '0;
  logic [6:0] in_class = '0;
  logic in_mc_hit = 1'b0;
  logic [3:0] in_mc_idx = '0;
  logic in_da_hit = 1'b0;
  logic [2:0] in_da_queue = '0;
  logic in_vlan_hit = 1'b0;
  logic [2:0] in_vlan_queue = '0;
  logic [17:0] cfg_order = '0;
  logic [5:0] cfg_enable = '0;
  logic [2:0] cfg_default_q = '0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_sel = '0;
  logic [6:0] tbl_addr = '0;
  logic [6:0] tbl_data = '0;
  logic out_valid;
  logic [2:0] out_queue;
  logic [7:0] out_tos;
  logic out_rewrite;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  qsel_top dut_i (.*);

  typedef struct packed {
    logic [17:0] order;
    logic [5:0]  en;
    logic [2:0]  pcp;
    logic [7:0]  tos;
    logic [6:0]  cls;
    logic        mch;
    logic [3:0]  mci;
    logic        dah;
    logic [2:0]  daq;
    logic        vh;
    logic [2:0]  vq;
    logic [2:0]  eq;
    logic [7:0]  etos;
    logic        erw;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{{3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 6'h3F, 3'd5, 8'hA3, 7'd10, 1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd1, 8'hBB, 1'b1},
    '{{3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 6'h3F, 3'd2, 8'hA1, 7'd5,  1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd6, 8'hA1, 1'b0},
    '{{3'd5,3'd4,3'd3,3'd1,3'd0,3'd2}, 6'h3F, 3'd7, 8'h00, 7'd100,1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd2, 8'h00, 1'b0},
    '{{3'd2,3'd1,3'd0,3'd5,3'd4,3'd3}, 6'h3F, 3'd0, 8'h12, 7'd10, 1'b1, 4'd3, 1'b0, 3'd0, 1'b0, 3'd0, 3'd5, 8'hBA, 1'b1},
    '{{3'd2,3'd1,3'd0,3'd5,3'd4,3'd3}, 6'h3F, 3'd0, 8'h00, 7'd0,  1'b0, 4'd3, 1'b1, 3'd4, 1'b0, 3'd0, 3'd4, 8'h00, 1'b0},
    '{{3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 6'h3F, 3'd0, 8'h00, 7'd0,  1'b0, 4'd0, 1'b1, 3'd6, 1'b1, 3'd0, 3'd0, 8'h00, 1'b0},
    '{{3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 6'h1F, 3'd0, 8'h00, 7'd0,  1'b0, 4'd0, 1'b1, 3'd6, 1'b1, 3'd0, 3'd6, 8'h00, 1'b0},
    '{{3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 6'h3F, 3'd0, 8'h00, 7'd20, 1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd3, 8'h28, 1'b1},
    '{{3'd4,3'd2,3'd1,3'd0,3'd5,3'd3}, 6'h3F, 3'd0, 8'h00, 7'd0,  1'b1, 4'd4, 1'b0, 3'd0, 1'b1, 3'd2, 3'd2, 8'h00, 1'b0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R5";
      1: return "R4";
      2: return "R5";
      3: return "R9";
      4: return "R4";
      5: return "R3";
      6: return "R6";
      7: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input logic [2:0] sel, input logic [6:0] addr,
                           input logic [6:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = addr; tbl_data = data;
    @(posedge clk);
    #1;
    tbl_we = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    cfg_order = v.order; cfg_enable = v.en;
    in_pcp = v.pcp; in_tos = v.tos; in_class = v.cls;
    in_mc_hit = v.mch; in_mc_idx = v.mci;
    in_da_hit = v.dah; in_da_queue = v.daq;
    in_vlan_hit = v.vh; in_vlan_queue = v.vq;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfg_default_q = 3'd3;
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset out_valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: empty tables give the default queue, unchanged ToS
    @(negedge clk);
    in_valid = 1'b1;
    cfg_order = {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}; cfg_enable = 6'h3F;
    in_pcp = 3'd7; in_tos = 8'hA0; in_class = 7'd10;
    @(posedge clk); #1;
    check("R1 out_valid after record", int'(out_valid), 1);
    check("R2 queue with empty tables", int'(out_queue), 3);
    check("R2 tos unchanged", int'(out_tos), 'hA0);
    check("R2 no rewrite", int'(out_rewrite), 0);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 idle gives no decision", int'(out_valid), 0);

    // R8: program sparse tables
    for (int p = 4; p < 8; p++) tbl_write(3'd0, 7'(p), {3'b000, 1'b1, 3'(p - 4)});
    tbl_write(3'd1, 7'd5, 7'h0E);
    tbl_write(3'd2, 7'd10, 7'h0F);
    tbl_write(3'd2, 7'd100, 7'h0A);
    tbl_write(3'd3, 7'd3, 7'h0D);
    tbl_write(3'd4, 7'd10, 7'h6E);
    tbl_write(3'd4, 7'd20, 7'h4A);

    // Back-to-back vector walk
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      apply(VECS[i]);
      @(posedge clk); #1;
      check({vec_tag(i), " valid"}, int'(out_valid), 1);
      check({vec_tag(i), " queue"}, int'(out_queue), int'(VECS[i].eq));
      check({vec_tag(i), " tos"}, int'(out_tos), int'(VECS[i].etos));
      check({vec_tag(i), " rewrite"}, int'(out_rewrite), int'(VECS[i].erw));
    end

    // R8: write and lookup in the same cycle sees old contents
    @(negedge clk);
    cfg_order = {3'd5,3'd4,3'd3,3'd1,3'd0,3'd2}; cfg_enable = 6'h3F;
    in_pcp = 3'd0; in_tos = 8'h00; in_class = 7'd50;
    in_mc_hit = 1'b0; in_da_hit = 1'b0; in_vlan_hit = 1'b0;
    in_valid = 1'b1;
    tbl_we = 1'b1; tbl_sel = 3'd2; tbl_addr = 7'd50; tbl_data = 7'h09;
    @(posedge clk); #1;
    check("R8 same-cycle write not seen", int'(out_queue), 3);
    @(negedge clk);
    tbl_we = 1'b0;
    @(posedge clk); #1;
    check("R8 written entry seen next", int'(out_queue), 1);

    // R10: unused selectors leave every table intact
    @(negedge clk);
    in_valid = 1'b0;
    for (int s = 5; s < 8; s++) tbl_write(3'(s), 7'd50, 7'h7F);
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk); #1;
    check("R10 class entry kept", int'(out_queue), 1);
    check("R10 no remark created", int'(out_rewrite), 0);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule